// File: doc/BRIEF.md
# Programmable High/Low-Time Clock Divider

This block divides a fast input clock by a ratio given as two separate phase lengths: how many input cycles the output spends high, and how many it spends low. The period of the divided clock is the sum of the two. The configuration word has three more bits: a parity marker for odd ratios, a pass-through flag that forwards the input clock unchanged, and a hold bit that makes the block ignore an apply request.

A new word is offered with a one-cycle apply strobe. The block holds it as pending and installs it only when the current output period ends, so the output never carries a shortened pulse. If several words arrive within one period, the last accepted one wins. A word with both counts zero and pass-through clear is refused, and a sticky error flag records the refusal. Besides the divided clock, the block produces a one-input-cycle pulse that marks each rising edge of the output. After reset the block is in pass-through.

Top module: `hilo_clk_div`

## Requirements
- R1: Bits 5:0 of the word are the low-phase length and bits 11:6 the high-phase length, both in input cycles. When both are non-zero, the output is high for the high length, then low for the low length, and repeats with a period equal to their sum.
- R2: An odd ratio coded with the low length one larger than the high length gives an odd period, and the extra cycle falls in the low phase.
- R3: Bit 12, the odd-ratio marker, does not change the timing. The period is still the sum of the two lengths.
- R4: With bit 13 set, the output follows the input clock and the two lengths are ignored. The rise pulse is high in every input cycle.
- R5: An apply strobe with bit 14 set is ignored, and the current timing continues unchanged.
- R6: An apply of a word with both lengths zero and bit 13 clear is refused. The previous timing stays, and the error output goes to 1 and stays there until reset.
- R7: An accepted word takes effect only at the end of the output period in progress, which finishes with the old timing. If several words are accepted within one period, the last one is installed.
- R8: After reset the block is in pass-through, the rise pulse is high and the error output is 0.
- R9: Outside pass-through, the rise pulse is high for exactly the first input cycle in which the output is high after being low.
- R10: A zero high length with a non-zero low length holds the output low with no rise pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWord | input | 15 | Configuration word: low length, high length, odd marker, pass-through, hold |
| applyStb | input | 1 | One-cycle request to take cfgWord |
| divClk | output | 1 | Divided output clock |
| riseStb | output | 1 | One-cycle marker of each rising output edge |
| cfgErr | output | 1 | Sticky flag for a refused all-zero word |

## Verification
The assertions check the following on every cycle:
- the error flag is set by an all-zero apply and then never clears;
- the active setting changes only in a cycle that closes a period;
- outside pass-through, every rise pulse coincides with a low-to-high step of the registered output level;
- the block leaves reset in pass-through.

Only the bench scenarios can show that each period has the right length and high-phase count for a given word. The same holds for these cases:
- the period in progress finishes with the old timing before a change;
- the last of several words is the one installed;
- the hold bit, the odd marker and the all-zero word leave the timing untouched;
- a zero high length gives a constant low output.

// File: rtl/hilo_div_pkg.sv
package hilo_div_pkg;

  localparam int FIELD_W = 6;
  localparam int WORD_W  = 2 * FIELD_W + 3;

  // Decoded setting held by the datapath
  typedef struct packed {
    logic               bypass;
    logic [FIELD_W-1:0] highLen;
    logic [FIELD_W-1:0] lowLen;
  } divCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic commit;    // install pending setting now
    logic toBypass;  // the installed setting is pass-through
  } ctrlStb_t;

endpackage

// File: rtl/hilo_div_ctrl.sv
module hilo_div_ctrl
  import hilo_div_pkg::*;
#(
  parameter int FW = FIELD_W,
  localparam int WW = 2 * FW + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [WW-1:0] cfgWord,
  input  logic          applyStb,
  input  logic          periodEnd,
  output ctrlStb_t      stb,
  output divCfg_t       pendCfg,
  output logic          cfgErr
);

  localparam int HOLD_BIT = 2 * FW + 2;
  localparam int BYP_BIT  = 2 * FW + 1;

  logic          pendValid;
  logic [FW-1:0] wordHigh;
  logic [FW-1:0] wordLow;
  logic          wordByp;
  logic          wordHold;
  logic          wordEmpty;
  logic          accept;
  logic          reject;

  assign wordLow   = cfgWord[FW-1:0];
  assign wordHigh  = cfgWord[2*FW-1:FW];
  assign wordByp   = cfgWord[BYP_BIT];
  assign wordHold  = cfgWord[HOLD_BIT];
  assign wordEmpty = (wordHigh == '0) && (wordLow == '0);
  assign accept    = applyStb && !wordHold && (wordByp || !wordEmpty);
  assign reject    = applyStb && !wordHold && !wordByp && wordEmpty;

  always_comb begin
    stb.commit   = pendValid && periodEnd;
    stb.toBypass = pendValid && periodEnd && pendCfg.bypass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendCfg   <= '{bypass: 1'b1, highLen: '0, lowLen: '0};
    end else if (accept) begin
      pendValid <= 1'b1;
      pendCfg   <= '{bypass: wordByp, highLen: wordHigh, lowLen: wordLow};
    end else if (stb.commit) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cfgErr <= 1'b0;
    else if (reject) cfgErr <= 1'b1;
  end

endmodule

// File: rtl/hilo_div_dp.sv
module hilo_div_dp
  import hilo_div_pkg::*;
#(
  parameter int FW = FIELD_W,
  localparam int PW = FW + 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  input  divCfg_t  pendCfg,
  output divCfg_t  actCfg,
  output logic     periodEnd,
  output logic     divLevel,
  output logic     riseReg
);

  logic [PW-1:0] pos;
  logic [PW-1:0] ratio;
  logic [PW-1:0] nextPos;
  logic [FW-1:0] nextHigh;
  logic          nextByp;
  logic          nextLevel;
  logic          nextRise;

  assign ratio     = {1'b0, actCfg.highLen} + {1'b0, actCfg.lowLen};
  assign periodEnd = actCfg.bypass || (pos == ratio - 1'b1);

  always_comb begin
    if (stb.commit) begin
      nextPos  = '0;
      nextByp  = stb.toBypass;
      nextHigh = pendCfg.highLen;
    end else begin
      nextPos  = periodEnd ? '0 : pos + 1'b1;
      nextByp  = actCfg.bypass;
      nextHigh = actCfg.highLen;
    end
    nextLevel = !nextByp && (nextPos < {1'b0, nextHigh});
    // in pass-through the level before each edge is low
    nextRise  = nextLevel && (actCfg.bypass || !divLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg   <= '{bypass: 1'b1, highLen: '0, lowLen: '0};
      pos      <= '0;
      divLevel <= 1'b0;
      riseReg  <= 1'b0;
    end else begin
      if (stb.commit) actCfg <= pendCfg;
      pos      <= nextPos;
      divLevel <= nextLevel;
      riseReg  <= nextRise;
    end
  end

endmodule

// File: rtl/hilo_clk_div.sv
module hilo_clk_div
  import hilo_div_pkg::*;
#(
  parameter int FIELD_W_P = FIELD_W,
  localparam int WW = 2 * FIELD_W_P + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [WW-1:0] cfgWord,
  input  logic          applyStb,
  output logic          divClk,
  output logic          riseStb,
  output logic          cfgErr
);

  ctrlStb_t stb;
  divCfg_t  pendCfg;
  divCfg_t  actCfg;
  logic     periodEnd;
  logic     divLevel;
  logic     riseReg;
  logic     activeByp;

  hilo_div_ctrl #(.FW(FIELD_W_P)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWord   (cfgWord),
    .applyStb  (applyStb),
    .periodEnd (periodEnd),
    .stb       (stb),
    .pendCfg   (pendCfg),
    .cfgErr    (cfgErr)
  );

  hilo_div_dp #(.FW(FIELD_W_P)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pendCfg   (pendCfg),
    .actCfg    (actCfg),
    .periodEnd (periodEnd),
    .divLevel  (divLevel),
    .riseReg   (riseReg)
  );

  assign activeByp = actCfg.bypass;
  assign divClk    = activeByp ? clk : divLevel;
  assign riseStb   = activeByp || riseReg;

endmodule

// File: rtl/hilo_clk_div_chk.sv
module hilo_clk_div_chk
  import hilo_div_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] cfgWord,
  input logic              applyStb,
  input logic              riseStb,
  input logic              cfgErr,
  input logic              activeByp,
  input logic              periodEnd,
  input logic              divLevel,
  input divCfg_t           actCfg
);

  AST_ZERO_WORD_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (applyStb && !cfgWord[2*FIELD_W+2] && !cfgWord[2*FIELD_W+1] &&
     cfgWord[2*FIELD_W-1:0] == '0) |=> cfgErr);  // R6

  AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);  // R6

  AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actCfg) |-> $past(periodEnd));  // R7

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (riseStb && !activeByp) |-> (divLevel && !$past(divLevel)));  // R9

  AST_RESET_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (activeByp && riseStb && !cfgErr));  // R8

endmodule

bind hilo_clk_div hilo_clk_div_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWord   (cfgWord),
  .applyStb  (applyStb),
  .riseStb   (riseStb),
  .cfgErr    (cfgErr),
  .activeByp (activeByp),
  .periodEnd (periodEnd),
  .divLevel  (divLevel),
  .actCfg    (actCfg)
);

// File: tb/test_hilo_clk_div.sv
module test_hilo_clk_div;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] cfgWord = '0;
  logic        applyStb = 1'b0;
  logic        divClk;
  logic        riseStb;
  logic        cfgErr;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    int    hi;
    int    per;
    string req;
  } item_t;

  item_t expQ[$];

  bit curByp = 1'b1;
  int curH = 0;
  int curL = 0;

  hilo_clk_div i_hilo_clk_div (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWord  (cfgWord),
    .applyStb (applyStb),
    .divClk   (divClk),
    .riseStb  (riseStb),
    .cfgErr   (cfgErr)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] mk(input bit hold, input bit byp, input bit odd,
                                     input int h, input int l);
    return {hold, byp, odd, h[5:0], l[5:0]};
  endfunction

  task automatic pushCur(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.hi  = curByp ? 1 : curH;
      it.per = curByp ? 1 : curH + curL;
      it.req = req;
      expQ.push_back(it);
    end
  endtask

  // monitor: measures each period from one rise pulse to the next
  initial begin
    bit inPeriod = 1'b0;
    int per = 0;
    int hi = 0;
    forever begin
      @(posedge clk);
      #1;
      if (!rstN) begin
        inPeriod = 1'b0;
      end else begin
        if (riseStb) begin
          if (inPeriod && expQ.size() > 0) begin
            item_t it;
            it = expQ.pop_front();
            chk(per == it.per, {it.req, " period"}, per, it.per);
            chk(hi == it.hi, {it.req, " high"}, hi, it.hi);
          end
          inPeriod = 1'b1;
          per = 0;
          hi = 0;
        end
        if (inPeriod) begin
          per++;
          if (divClk) hi++;
        end
      end
    end
  end

  task automatic syncRise();
    do begin
      @(posedge clk);
      #2;
    end while (!riseStb);
  endtask

  task automatic pulseApply(input logic [14:0] w);
    cfgWord  = w;
    applyStb = 1'b1;
    @(posedge clk);
    #2;
    applyStb = 1'b0;
  endtask

  task automatic waitDrain(input string req);
    int t = 0;
    while (expQ.size() > 0 && t < 3000) begin
      @(posedge clk);
      t++;
    end
    if (expQ.size() > 0) begin
      chk(1'b0, {req, " drain"}, expQ.size(), 0);
      expQ.delete();
    end
  endtask

  task automatic runCfg(input logic [14:0] w, input string req);
    bit accepted;
    accepted = !w[14] && (w[13] || w[11:0] != 0);
    syncRise();
    pushCur(curByp ? 2 : 1, "R7");
    pulseApply(w);
    if (accepted) begin
      curByp = w[13];
      curH   = int'(w[11:6]);
      curL   = int'(w[5:0]);
    end
    pushCur(4, req);
    waitDrain(req);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(posedge clk);
    #1;
    // R8: pass-through after reset
    chk(divClk == 1'b1, "R8 divClk", int'(divClk), 1);
    chk(riseStb == 1'b1, "R8 riseStb", int'(riseStb), 1);
    chk(cfgErr == 1'b0, "R8 cfgErr", int'(cfgErr), 0);

    runCfg(mk(0, 0, 0, 2, 2), "R1");
    runCfg(mk(0, 0, 0, 5, 5), "R1");
    runCfg(mk(0, 0, 1, 2, 3), "R2");
    runCfg(mk(0, 0, 1, 3, 3), "R3");
    runCfg(mk(1, 0, 0, 1, 6), "R5");
    runCfg(mk(0, 0, 0, 0, 0), "R6");
    #1;
    chk(cfgErr == 1'b1, "R6 flag set", int'(cfgErr), 1);

    // R7: latest of two words within one period is installed
    runCfg(mk(0, 0, 0, 5, 5), "R7");
    syncRise();
    pushCur(1, "R7");
    pulseApply(mk(0, 0, 0, 1, 1));
    pulseApply(mk(0, 0, 0, 3, 4));
    curH = 3;
    curL = 4;
    pushCur(4, "R7");
    waitDrain("R7");

    runCfg(mk(0, 1, 0, 7, 9), "R4");
    runCfg(mk(0, 0, 0, 1, 1), "R9");
    runCfg(mk(0, 0, 0, 4, 2), "R9");

    // R10: zero high length gives constant low output
    syncRise();
    pulseApply(mk(0, 0, 0, 0, 3));
    repeat (20) @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      chk(divClk == 1'b0, "R10 divClk", int'(divClk), 0);
      chk(riseStb == 1'b0, "R10 riseStb", int'(riseStb), 0);
    end
    #1;
    pulseApply(mk(0, 1, 0, 0, 0));
    repeat (10) @(posedge clk);
    #1;
    chk(divClk == 1'b1, "R4 divClk", int'(divClk), 1);
    chk(riseStb == 1'b1, "R4 riseStb", int'(riseStb), 1);
    chk(cfgErr == 1'b1, "R6 sticky", int'(cfgErr), 1);
    curByp = 1'b1;
    #1;
    runCfg(mk(0, 0, 0, 6, 1), "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule